// File: doc/BRIEF.md
# Capability Linked-List Walker

This block searches a chain of capability registers in a memory-mapped register space for the first entry carrying a requested ID. A start pulse loads the target ID. The walker first reads a header word at a fixed byte offset, and takes the offset of the first entry from the upper half of that word. It then reads one entry at a time and follows each entry's next pointer until one of these things happens: an ID matches, the chain ends, a visit budget runs out, or the next address would go past the top of the 16-bit address space.

Every pointer counts 32-bit words and is relative to the register that holds it. The header keeps its pointer in a different field from the entries. The walker reports a one-cycle done pulse with a found flag and the byte offset of the matching entry. The offset is zero when nothing was found. The read port has a valid/ready request channel and a response valid strobe. At most one read is in flight at a time.

Back-pressure rules: once the request valid is raised, the address stays unchanged and valid stays high until a cycle in which ready is sampled high. That cycle completes the transfer. The walker then waits for exactly one response strobe before it raises the next request. The response side has no ready signal, and a strobe is accepted only while the walker is waiting for one.

Top module: `cap_walker`

## Requirements
- R1: A start pulse while idle captures the target ID. From the next cycle busy is high, and the first request reads byte address 0x10 (the header word).
- R2: The first entry pointer is bits 31:16 of the header word. The first entry's byte address is 0x10 plus four times that pointer. A zero pointer ends the walk as not found after that single read.
- R3: In an entry word, bits 7:0 are the ID and bits 15:8 are the next pointer. The next byte address is the entry's address plus four times the pointer. Bits 31:16 of an entry have no effect on the walk.
- R4: The walk stops at the first entry whose ID equals the target and reports found=1 with that entry's byte address. No further reads follow.
- R5: A non-matching entry with a zero next pointer ends the walk with found=0 and offset 0.
- R6: At most 50 entries are read per walk. A match on the 50th entry is reported as found. Otherwise the walk ends as not found after 51 reads (the header plus 50 entries).
- R7: If a computed next address exceeds 0xFFFF, the walk ends as not found and that address is never requested.
- R8: done is a single-cycle pulse, and busy is low in that cycle. found and offset keep their values until the next done.
- R9: A start pulse while busy is ignored. Neither the target nor the reads of the walk in progress change.
- R10: A request whose ready is low keeps valid high and the address unchanged on the next cycle. Only one read is outstanding.
- R11: After reset, busy, done, found, offset and request valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| target_id_i | input | 8 | Capability ID to search for |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | Result of the last walk: match found |
| offset_o | output | 16 | Byte address of the matching entry, zero if none |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request ready |
| rd_req_addr_o | output | 16 | Byte address of the read |
| rd_rsp_valid_i | input | 1 | Read response strobe |
| rd_rsp_data_i | input | 32 | Read response word |

## Verification
Chains of zero to six entries with distinct IDs are searched for every ID from 0 to 11. This separates a hit at each position from a miss at the end of the chain, and the read count shows that the walk stops at the right place. A chain of repeated IDs shows that the first match wins. A sixty-entry chain with a target on the 50th or 51st entry shows exactly where the visit budget applies. Header and entry pointers that reach 0xFFFC or run past 0xFFFF show the boundary of the overflow rule. A pseudo-random ready and a response latency of one to three cycles run under every case, and a start pulse injected in the middle of a long walk tests that a busy walker ignores it.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [1:0] {
    CW_IDLE = 2'd0,
    CW_REQ  = 2'd1,
    CW_WAIT = 2'd2
  } cw_state_e;
endpackage

// File: rtl/cw_next_addr.sv
// Next-address arithmetic: base plus a word-count pointer, with a carry-out flag
module cw_next_addr #(
  parameter int ADDR_W = 16,
  parameter int PTR_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [ADDR_W-1:0] next_o,
  output logic              ovf_o,
  output logic              zero_o
);
  localparam int SUM_W = ((ADDR_W > PTR_W + 2) ? ADDR_W : PTR_W + 2) + 1;

  logic [SUM_W-1:0] sum;

  assign sum    = SUM_W'(base_i) + (SUM_W'(ptr_i) << 2);
  assign next_o = sum[ADDR_W-1:0];
  assign ovf_o  = |sum[SUM_W-1:ADDR_W];
  assign zero_o = (ptr_i == '0);
endmodule

// File: rtl/cw_visit_ctr.sv
// Counts entries visited in the current walk; flags the last permitted visit
module cw_visit_ctr #(
  parameter int MAX_VISITS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  localparam int CW = $clog2(MAX_VISITS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit_o = (cnt_q == CW'(MAX_VISITS - 1));
endmodule

// File: rtl/cap_walker.sv
module cap_walker import cw_pkg::*; #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int ID_W       = 8,
  parameter int NEXT_W     = 8,
  parameter int HEAD_LSB   = 16,
  parameter int HEAD_W     = 16,
  parameter int PARAM_OFS  = 16,
  parameter int MAX_VISITS = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ID_W-1:0]   target_id_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic [ADDR_W-1:0] offset_o,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  input  logic [DATA_W-1:0] rd_rsp_data_i
);
  localparam int PTR_W = (HEAD_W > NEXT_W) ? HEAD_W : NEXT_W;

  cw_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              head_q;
  logic [ID_W-1:0]   target_q;
  logic              done_q, found_q;
  logic [ADDR_W-1:0] off_q;

  logic [PTR_W-1:0]  ptr_sel;
  logic [ADDR_W-1:0] next_addr;
  logic              ptr_ovf, ptr_zero;
  logic              at_limit, id_hit;
  logic              accept_start, rsp_take, entry_rsp;

  assign accept_start = (state_q == CW_IDLE) && start_i;
  assign rsp_take     = (state_q == CW_WAIT) && rd_rsp_valid_i;
  assign entry_rsp    = rsp_take && !head_q;
  assign id_hit       = (rd_rsp_data_i[ID_W-1:0] == target_q);
  assign ptr_sel      = head_q ? PTR_W'(rd_rsp_data_i[HEAD_LSB +: HEAD_W])
                               : PTR_W'(rd_rsp_data_i[ID_W +: NEXT_W]);

  cw_next_addr #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_next (
    .base_i (addr_q),
    .ptr_i  (ptr_sel),
    .next_o (next_addr),
    .ovf_o  (ptr_ovf),
    .zero_o (ptr_zero)
  );

  cw_visit_ctr #(.MAX_VISITS(MAX_VISITS)) u_visits (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (accept_start),
    .inc_i      (entry_rsp),
    .at_limit_o (at_limit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CW_IDLE;
      addr_q   <= '0;
      head_q   <= 1'b0;
      target_q <= '0;
      done_q   <= 1'b0;
      found_q  <= 1'b0;
      off_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        CW_IDLE: begin
          if (start_i) begin
            target_q <= target_id_i;
            addr_q   <= ADDR_W'(PARAM_OFS);
            head_q   <= 1'b1;
            state_q  <= CW_REQ;
          end
        end
        CW_REQ: begin
          if (rd_req_ready_i) state_q <= CW_WAIT;
        end
        CW_WAIT: begin
          if (rd_rsp_valid_i) begin
            if (!head_q && id_hit) begin
              state_q <= CW_IDLE;
              done_q  <= 1'b1;
              found_q <= 1'b1;
              off_q   <= addr_q;
            end else if ((!head_q && at_limit) || ptr_zero || ptr_ovf) begin
              state_q <= CW_IDLE;
              done_q  <= 1'b1;
              found_q <= 1'b0;
              off_q   <= '0;
            end else begin
              addr_q  <= next_addr;
              head_q  <= 1'b0;
              state_q <= CW_REQ;
            end
          end
        end
        default: state_q <= CW_IDLE;
      endcase
    end
  end

  assign busy_o         = (state_q != CW_IDLE);
  assign done_o         = done_q;
  assign found_o        = found_q;
  assign offset_o       = off_q;
  assign rd_req_valid_o = (state_q == CW_REQ);
  assign rd_req_addr_o  = addr_q;
endmodule

// File: rtl/cap_walker_chk.sv
module cap_walker_chk #(
  parameter int ADDR_W    = 16,
  parameter int PARAM_OFS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              found_o,
  input logic [ADDR_W-1:0] offset_o,
  input logic              rd_req_valid_o,
  input logic              rd_req_ready_i,
  input logic [ADDR_W-1:0] rd_req_addr_o
);
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);
  a_r1_header_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (rd_req_valid_o && rd_req_addr_o == ADDR_W'(PARAM_OFS)));
  a_r4_hit_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && found_o) |-> (offset_o[1:0] == 2'b00 && offset_o != '0));
  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !found_o) |-> (offset_o == '0));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(found_o) && $stable(offset_o)));
  a_r9_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && !rd_req_ready_i) |=> (rd_req_valid_o && $stable(rd_req_addr_o)));
endmodule

bind cap_walker cap_walker_chk #(.ADDR_W(ADDR_W), .PARAM_OFS(PARAM_OFS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .found_o        (found_o),
  .offset_o       (offset_o),
  .rd_req_valid_o (rd_req_valid_o),
  .rd_req_ready_i (rd_req_ready_i),
  .rd_req_addr_o  (rd_req_addr_o)
);

// File: tb/tb_cap_walker.sv
`timescale 1ns/1ps
module tb_cap_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  target_id_i = '0;
  logic        busy_o, done_o, found_o;
  logic [15:0] offset_o;
  logic        rd_req_valid_o;
  logic        rd_req_ready_i = 1'b0;
  logic [15:0] rd_req_addr_o;
  logic        rd_rsp_valid_i = 1'b0;
  logic [31:0] rd_rsp_data_i = '0;

  int errors = 0;
  int checks = 0;
  int reads  = 0;
  bit stall_seen = 0;
  logic [31:0] mem [0:1023];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  cap_walker dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_id_i(target_id_i),
    .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .offset_o(offset_o),
    .rd_req_valid_o(rd_req_valid_o), .rd_req_ready_i(rd_req_ready_i),
    .rd_req_addr_o(rd_req_addr_o), .rd_rsp_valid_i(rd_rsp_valid_i),
    .rd_rsp_data_i(rd_rsp_data_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Responder: pseudo-random ready, 1..3 cycle response latency, address aliased to 4 KiB
  initial begin
    forever begin
      @(negedge clk);
      rd_rsp_valid_i = 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_req_ready_i = lfsr[0] | lfsr[3];
      if (rd_req_valid_o && !rd_req_ready_i) stall_seen = 1;
      if (rd_req_valid_o && rd_req_ready_i) begin
        logic [15:0] a;
        int lat;
        a = rd_req_addr_o;
        reads++;
        lat = 1 + (int'(lfsr[6:5]) % 3);
        repeat (lat) @(negedge clk);
        rd_rsp_data_i  = mem[a[11:2]];
        rd_rsp_valid_i = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask

  task automatic put(input logic [15:0] a, input logic [31:0] w);
    mem[a[11:2]] = w;
  endtask

  // Run a walk; if poke is set, a second start with another target arrives mid-walk
  task automatic run(input logic [7:0] tgt, input bit ex_f, input logic [15:0] ex_off,
                     input int ex_reads, input string req, input bit poke);
    int cyc;
    @(negedge clk);
    reads = 0;
    start_i = 1'b1;
    target_id_i = tgt;
    @(negedge clk);
    start_i = 1'b0;
    target_id_i = 8'h00;
    chk(busy_o == 1'b1, "R1", "busy after start", busy_o, 1);
    if (poke) begin
      @(negedge clk);
      start_i = 1'b1;
      target_id_i = tgt ^ 8'h13;
      @(negedge clk);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!done_o && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done_o == 1'b1, req, "done seen", done_o, 1);
    chk(found_o == ex_f, req, "found", found_o, ex_f);
    chk(offset_o == ex_off, req, "offset", offset_o, ex_off);
    chk(reads == ex_reads, req, "read count", reads, ex_reads);
    chk(busy_o == 1'b0, "R8", "busy low at done", busy_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R8", "done single cycle", done_o, 0);
    chk(found_o == ex_f && offset_o == ex_off, "R8", "result held",
        {found_o, offset_o}, {ex_f, ex_off});
  endtask

  initial begin
    logic [7:0]  ids [0:5];
    logic [15:0] addrs [0:5];
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy_o == 0 && done_o == 0 && found_o == 0 && offset_o == 0 && rd_req_valid_o == 0,
        "R11", "reset outputs", {busy_o, done_o, found_o, offset_o, rd_req_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: chains of 0..6 entries, every target 0..11
    for (int len = 0; len <= 6; len++) begin
      clear_mem();
      put(16'h0010, (len == 0) ? 32'h0 : {16'd12, 16'h0});
      for (int k = 0; k < len; k++) begin
        addrs[k] = (k == 0) ? 16'h0040 : addrs[k-1] + 16'(4 * (k + 1));
        ids[k]   = 8'((k * 5 + len) % 12);
        put(addrs[k], {16'hA5A5 ^ 16'(k), (k == len - 1) ? 8'd0 : 8'(k + 2), ids[k]});
      end
      for (int t = 0; t < 12; t++) begin
        int hit;
        hit = -1;
        for (int k = 0; k < len; k++) if (hit < 0 && ids[k] == 8'(t)) hit = k;
        if (hit >= 0) run(8'(t), 1'b1, addrs[hit], hit + 2, "R4", 1'b0);
        else          run(8'(t), 1'b0, 16'h0, len + 1, (len == 0) ? "R2" : "R5", 1'b0);
      end
    end

    // R4: repeated IDs, the first one wins
    clear_mem();
    put(16'h0010, {16'd4, 16'h0});
    put(16'h0020, {16'hFFFF, 8'd2, 8'd7});
    put(16'h0028, {16'h1234, 8'd2, 8'd7});
    put(16'h0030, {16'h0000, 8'd0, 8'd7});
    run(8'd7, 1'b1, 16'h0020, 2, "R4", 1'b0);

    // R6 R9: 60 consecutive entries, budget of 50 visits
    clear_mem();
    put(16'h0010, {16'h003C, 16'h0});
    for (int k = 0; k < 60; k++)
      put(16'(16'h0100 + 4 * k), {16'h0, (k == 59) ? 8'd0 : 8'd1,
                                  (k == 49) ? 8'h31 : (k == 50) ? 8'h32 : 8'h20});
    run(8'h31, 1'b1, 16'h01C4, 51, "R6", 1'b0);
    run(8'h32, 1'b0, 16'h0000, 51, "R6", 1'b0);
    run(8'h31, 1'b1, 16'h01C4, 51, "R9", 1'b1);
    run(8'h20, 1'b1, 16'h0100, 2, "R6", 1'b0);

    // R7: overflow on the header pointer
    clear_mem();
    put(16'h0010, {16'hFFFF, 16'h0});
    run(8'd1, 1'b0, 16'h0, 1, "R7", 1'b0);
    // R7: entry at 0xFC00, then 0xFFFC (highest legal), whose pointer overflows
    clear_mem();
    put(16'h0010, {16'h3EFC, 16'h0});
    put(16'hFC00, {16'h0, 8'hFF, 8'd3});
    put(16'hFFFC, {16'h0, 8'h01, 8'd4});
    run(8'd4, 1'b1, 16'hFFFC, 3, "R7", 1'b0);
    run(8'd5, 1'b0, 16'h0000, 3, "R7", 1'b0);

    // R10: back-pressure was exercised with the request held (also asserted)
    chk(stall_seen == 1'b1, "R10", "ready stall exercised", stall_seen, 1);
    report();
  end
endmodule